// File: doc/BRIEF.md
# Cascadable Row-Scan Token Shifter

This block drives the row side of a passive dot-matrix display. A chain of `ROWS` stages holds at most a few single-bit tokens. Each active edge of a slow line clock moves every token one row further. A high stage marks the row that is selected for the current line period. For every row the block combines the stage bit with the frame-polarity input into a 2-bit code. An external analog switch uses this code to pick one of four bias levels.

The line clock is sampled in the fast system clock domain. A two-state phase machine (`PH_LOW`, `PH_HIGH`) follows its level. The transition `PH_LOW -> PH_HIGH` is the rising edge and `PH_HIGH -> PH_LOW` is the falling edge. A strap input chooses which of the two transitions produces a shift strobe. Scan direction is also strapped. In master mode the token comes in from the frame-start input. In slave mode it comes in through one of two cascade pins, and the other pin carries the token onward to the next device. Each cascade pin is split into input, output and output-enable, so a pad can be built around it.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst_n` is low, every stage is cleared. Every row then shows the non-selected code for the present `pol`, and both cascade outputs are 0.
- R2: In master mode, a shift strobe loads `frame_start` into the first row. The first row is row 0 when `scan_up`=1 and row `ROWS`-1 when `scan_up`=0. Row `r` occupies `lvl_sel[2r+1:2r]`.
- R3: With `scan_up`=1, a shift strobe moves the token in row k to row k+1. A token in row `ROWS`-1 leaves the block and does not wrap around.
- R4: With `scan_up`=0, a shift strobe moves the token in row k to row k-1. A token in row 0 leaves the block and does not wrap around.
- R5: The downstream cascade pin drives the bit of the last row for as long as that row is selected. This is pin B (row `ROWS`-1) when scanning up and pin A (row 0) when scanning down. The other pin drives 0 whenever it is an output.
- R6: Pin directions follow this table. In master mode both enables are 1. In slave mode with `scan_up`=1, `casc_a_oe`=0 and `casc_b_oe`=1. In slave mode with `scan_up`=0, `casc_a_oe`=1 and `casc_b_oe`=0.
- R7: In slave mode the token input is `casc_a_in` when scanning up and `casc_b_in` when scanning down. The unused cascade input and `frame_start` have no effect.
- R8: With `edge_rise`=1, only a low-to-high change of `line_clk` shifts. With `edge_rise`=0, only a high-to-low change shifts. The stages update on the first `clk` rising edge that samples the new level, and they hold in every other cycle.
- R9: The row code is chosen from `pol` and the stage bit as follows. With pol=0, a clear bit gives 01 and a set bit gives 11. With pol=1, a clear bit gives 10 and a set bit gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Line clock; one period per row |
| edge_rise | input | 1 | Strap: 1 shifts on rising line edge, 0 on falling |
| is_master | input | 1 | Strap: 1 master, 0 slave |
| scan_up | input | 1 | Strap: 1 scans row 0 upward, 0 scans downward |
| frame_start | input | 1 | Token source in master mode |
| pol | input | 1 | Frame polarity |
| casc_a_in | input | 1 | Cascade pin A input (row-0 end) |
| casc_b_in | input | 1 | Cascade pin B input (last-row end) |
| casc_a_out | output | 1 | Cascade pin A output value |
| casc_a_oe | output | 1 | Cascade pin A output enable |
| casc_b_out | output | 1 | Cascade pin B output value |
| casc_b_oe | output | 1 | Cascade pin B output enable |
| lvl_sel | output | 2*ROWS | Bias level code per row, row r at bits 2r+1:2r |

## Verification
Two things can happen on the same shift strobe. A new frame token can load into the first row while the previous token drops out of the last row and releases the downstream cascade pin. The bench provokes this with a master scan: it walks a token up to row 63 and then raises `frame_start` for the next strobe. It then expects only row 0 to be selected and pin B to return to 0 in the same cycle. A second overlap tests polarity against shifting: `pol` changes in the same strobe period as the token moves, and every row code is compared against the table for the new polarity.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V1 = 2'b01,
        LVL_V4 = 2'b10,
        LVL_V5 = 2'b11
    } lvl_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/rss_edge.sv
module rss_edge
    import rss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic edge_rise,
    output logic shift
);
    phase_e ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_LOW;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d  = ph_q;
        shift = 1'b0;
        unique case (ph_q)
            PH_LOW: begin
                if (line_clk) begin
                    ph_d  = PH_HIGH;
                    shift = edge_rise;
                end
            end
            PH_HIGH: begin
                if (!line_clk) begin
                    ph_d  = PH_LOW;
                    shift = !edge_rise;
                end
            end
        endcase
    end

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> !shift);
endmodule

// File: rtl/rss_chain.sv
module rss_chain #(
    parameter int ROWS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic            up,
    input  logic            tok_in,
    output logic [ROWS-1:0] q
);
    localparam int LAST = ROWS - 1;

    logic [ROWS-1:0] nxt;

    for (genvar k = 0; k < ROWS; k++) begin : g_stage
        logic from_low, from_high;
        if (k == 0) begin : g_first
            assign from_low = tok_in;
        end else begin : g_mid_lo
            assign from_low = q[k-1];
        end
        if (k == LAST) begin : g_last
            assign from_high = tok_in;
        end else begin : g_mid_hi
            assign from_high = q[k+1];
        end
        assign nxt[k] = up ? from_low : from_high;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= nxt;
    end

    // R3
    up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && up) |=> (q[LAST:1] == $past(q[LAST-1:0])));
    // R4
    down_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !up) |=> (q[LAST-1:0] == $past(q[LAST:1])));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(q));
endmodule

// File: rtl/rss_lvl.sv
module rss_lvl
    import rss_pkg::*;
#(
    parameter int ROWS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol,
    input  logic [ROWS-1:0]   q,
    output logic [2*ROWS-1:0] lvl
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        lvl_e code;
        always_comb begin
            unique case ({pol, q[r]})
                2'b00:   code = LVL_V1;
                2'b01:   code = LVL_V5;
                2'b10:   code = LVL_V4;
                default: code = LVL_V0;
            endcase
        end
        assign lvl[2*r +: 2] = code;

        // R9
        pol_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pol |-> (lvl[2*r +: 2] != LVL_V1 && lvl[2*r +: 2] != LVL_V5));
    end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
    parameter int ROWS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              edge_rise,
    input  logic              is_master,
    input  logic              scan_up,
    input  logic              frame_start,
    input  logic              pol,
    input  logic              casc_a_in,
    input  logic              casc_b_in,
    output logic              casc_a_out,
    output logic              casc_a_oe,
    output logic              casc_b_out,
    output logic              casc_b_oe,
    output logic [2*ROWS-1:0] lvl_sel
);
    localparam int LAST = ROWS - 1;

    logic            shift;
    logic            tok_in;
    logic [ROWS-1:0] rows_q;

    rss_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (line_clk),
        .edge_rise(edge_rise),
        .shift    (shift)
    );

    assign tok_in = is_master ? frame_start
                              : (scan_up ? casc_a_in : casc_b_in);

    rss_chain #(.ROWS(ROWS)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .up    (scan_up),
        .tok_in(tok_in),
        .q     (rows_q)
    );

    rss_lvl #(.ROWS(ROWS)) u_lvl (
        .clk  (clk),
        .rst_n(rst_n),
        .pol  (pol),
        .q    (rows_q),
        .lvl  (lvl_sel)
    );

    assign casc_a_oe  = is_master | ~scan_up;
    assign casc_b_oe  = is_master |  scan_up;
    assign casc_a_out = ~scan_up & rows_q[0];
    assign casc_b_out =  scan_up & rows_q[LAST];

    // R2
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && shift) |=> (scan_up ? rows_q[0] : rows_q[LAST]) == $past(frame_start));
    // R6
    slave_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (casc_a_oe != casc_b_oe));
    // R6
    some_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        casc_a_oe || casc_b_oe);
endmodule

// File: tb/test_row_scan_shifter.sv
module test_row_scan_shifter;
    localparam int ROWS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0, edge_rise = 1'b1, is_master = 1'b1, scan_up = 1'b1;
    logic frame_start = 1'b0, pol = 1'b0, casc_a_in = 1'b0, casc_b_in = 1'b0;
    logic casc_a_out, casc_a_oe, casc_b_out, casc_b_oe;
    logic [2*ROWS-1:0] lvl_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    row_scan_shifter #(.ROWS(ROWS)) i_row_scan_shifter (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .edge_rise(edge_rise),
        .is_master(is_master), .scan_up(scan_up), .frame_start(frame_start),
        .pol(pol), .casc_a_in(casc_a_in), .casc_b_in(casc_b_in),
        .casc_a_out(casc_a_out), .casc_a_oe(casc_a_oe),
        .casc_b_out(casc_b_out), .casc_b_oe(casc_b_oe), .lvl_sel(lvl_sel)
    );

    // {frame_start, pol, expected active row}; rows walk upward in master mode
    localparam logic [8:0] STEP_TAB [0:5] = '{
        9'b1_0_0000000,
        9'b0_1_0000001,
        9'b0_0_0000010,
        9'b0_1_0000011,
        9'b0_1_0000100,
        9'b0_0_0000101
    };

    function automatic logic [2*ROWS-1:0] exp_lvl(input int act, input logic p);
        logic [2*ROWS-1:0] v;
        for (int r = 0; r < ROWS; r++)
            v[2*r +: 2] = (r == act) ? (p ? 2'b00 : 2'b11) : (p ? 2'b10 : 2'b01);
        return v;
    endfunction

    task automatic check_lvl(input int act, input string tag);
        logic [2*ROWS-1:0] e;
        e = exp_lvl(act, pol);
        total++;
        if (lvl_sel !== e) begin
            bad++;
            $display("FAIL %s: lvl_sel actual=%h expected=%h (row %0d)", tag, lvl_sel, e, act);
        end
    endtask

    task automatic check_bit(input logic act_v, input logic exp_v, input string tag);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act_v, exp_v);
        end
    endtask

    task automatic line_pulse();
        @(negedge clk) line_clk = 1'b1;
        @(negedge clk) line_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m, input logic u);
        @(negedge clk);
        rst_n = 1'b0; line_clk = 1'b0; frame_start = 1'b0;
        casc_a_in = 1'b0; casc_b_in = 1'b0;
        is_master = m; scan_up = u;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state, both polarities
        do_reset(1'b1, 1'b1);
        check_lvl(-1, "R1 reset pol0");
        pol = 1'b1; @(negedge clk);
        check_lvl(-1, "R1 reset pol1");
        check_bit(casc_a_out, 1'b0, "R1 a_out");
        check_bit(casc_b_out, 1'b0, "R1 b_out");
        check_bit(casc_a_oe, 1'b1, "R6 master a_oe");
        check_bit(casc_b_oe, 1'b1, "R6 master b_oe");

        // R2 R3 R9 table walk, master upward
        for (int i = 0; i < 6; i++) begin
            frame_start = STEP_TAB[i][8];
            pol = STEP_TAB[i][7];
            line_pulse();
            frame_start = 1'b0;
            check_lvl(int'(STEP_TAB[i][6:0]), "R3 R9 walk");
        end
        repeat (57) line_pulse();
        check_lvl(62, "R3 row 62");
        check_bit(casc_b_out, 1'b0, "R5 b_out before last");
        line_pulse();
        check_lvl(63, "R3 row 63");
        check_bit(casc_b_out, 1'b1, "R5 b_out at last row");
        check_bit(casc_a_out, 1'b0, "R5 a_out idle");
        // overlap: reload and exit on the same strobe
        frame_start = 1'b1;
        line_pulse();
        frame_start = 1'b0;
        check_lvl(0, "R2 R3 reload while exiting");
        check_bit(casc_b_out, 1'b0, "R5 b_out released");

        // R1 reset in mid-scan
        line_pulse();
        rst_n = 1'b0; @(negedge clk);
        check_lvl(-1, "R1 mid-scan reset");
        rst_n = 1'b1; @(negedge clk);

        // R8 edge choice
        edge_rise = 1'b1;
        frame_start = 1'b1; line_clk = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        check_lvl(0, "R8 rising shifts");
        line_clk = 1'b0; @(negedge clk);
        check_lvl(0, "R8 falling ignored");
        edge_rise = 1'b0;
        line_clk = 1'b1; @(negedge clk);
        check_lvl(0, "R8 rising ignored");
        line_clk = 1'b0; @(negedge clk);
        check_lvl(1, "R8 falling shifts");
        repeat (3) @(negedge clk);
        check_lvl(1, "R8 hold without edge");
        edge_rise = 1'b1;

        // R4 R2 master downward
        do_reset(1'b1, 1'b0);
        check_bit(casc_a_oe, 1'b1, "R6 master down a_oe");
        check_bit(casc_b_oe, 1'b1, "R6 master down b_oe");
        frame_start = 1'b1; line_pulse(); frame_start = 1'b0;
        check_lvl(63, "R2 down load");
        check_bit(casc_b_out, 1'b0, "R5 b_out idle down");
        line_pulse();
        check_lvl(62, "R4 row 62");
        repeat (62) line_pulse();
        check_lvl(0, "R4 row 0");
        check_bit(casc_a_out, 1'b1, "R5 a_out at row 0");
        line_pulse();
        check_lvl(-1, "R4 no wrap");
        check_bit(casc_a_out, 1'b0, "R5 a_out after exit");

        // R7 R6 slave upward
        do_reset(1'b0, 1'b1);
        check_bit(casc_a_oe, 1'b0, "R6 slave up a_oe");
        check_bit(casc_b_oe, 1'b1, "R6 slave up b_oe");
        frame_start = 1'b1; line_pulse(); frame_start = 1'b0;
        check_lvl(-1, "R7 frame_start ignored");
        casc_a_in = 1'b1; line_pulse(); casc_a_in = 1'b0;
        check_lvl(0, "R7 capture from A");
        casc_b_in = 1'b1; line_pulse(); casc_b_in = 1'b0;
        check_lvl(1, "R7 B ignored when up");

        // R7 R6 slave downward
        do_reset(1'b0, 1'b0);
        check_bit(casc_a_oe, 1'b1, "R6 slave down a_oe");
        check_bit(casc_b_oe, 1'b0, "R6 slave down b_oe");
        casc_a_in = 1'b1; line_pulse(); casc_a_in = 1'b0;
        check_lvl(-1, "R7 A ignored when down");
        casc_b_in = 1'b1; line_pulse(); casc_b_in = 1'b0;
        check_lvl(63, "R7 capture from B");
        check_bit(casc_a_out, 1'b0, "R5 a_out while row 63");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule